// File: doc/BRIEF.md
# Step Pattern Toggle Store

This block holds the step patterns of a seven-channel, sixteen-step sequencer. Each memory word describes one step: bit n of the word says whether channel n fires on that step. Two complete patterns are stored, and a one-bit pattern select forms the top address bit above a four-bit step number. The word at the current pattern and step is presented continuously on a read output, for the display and for the trigger logic.

A channel selector with one line per channel is priority-encoded to a three-bit channel number. The same selection, reduced to a single bit, is the invert mask for a toggle. No single bit of the memory can be written on its own. A toggle therefore reads the whole word into a holding register with the selected bit inverted, then writes that register back to the same address. A clear sweeps all sixteen steps of the selected pattern and places zero on the shared write data bus for each step. It then raises a done flag for one cycle.

The controller is a five-state machine. The states are IDLE, CAPTURE, WRITE, CLEAR and DONE. The transitions are:
- IDLE→CLEAR when a clear is requested. This takes priority over a toggle.
- IDLE→CAPTURE when a toggle is requested.
- CAPTURE→WRITE unconditionally.
- WRITE→IDLE unconditionally.
- CLEAR→CLEAR while the step counter is below 15.
- CLEAR→DONE on the write to step 15.
- DONE→IDLE unconditionally.

Requests that arrive outside IDLE are dropped.

Top module: `step_pattern_store`

## Requirements
- R1: After reset, `busy` and `clear_done` are 0, and every word of both patterns reads 0.
- R2: When no operation is in progress, `rd_word` shows the word stored at address {`pat_sel`, `step`}. It follows a change of address within the same cycle.
- R3: `chan_num` is the index of the lowest-numbered set bit of `chan_sel[6:0]`, and it is 0 when no bit is set. When several bits are set, the invert mask holds only that lowest bit.
- R4: A toggle inverts exactly the bit `chan_num` of the addressed word and leaves the other seven bits unchanged. Bit 7 is never inverted. With `chan_sel` all zero, a toggle leaves the word unchanged.
- R5: A toggle request seen at a clock edge in IDLE raises `busy` for exactly the two following cycles, CAPTURE and then WRITE. The new word is readable after the second edge after the request.
- R6: Toggle requests seen during CAPTURE or WRITE are ignored. A request held high for three edges produces a single inversion.
- R7: A clear writes zero to all 16 steps of the pattern that was selected when the clear was accepted. The other pattern is left unchanged.
- R8: After an accepted clear, `busy` is high for exactly 16 cycles, one write per cycle. `clear_done` is then high for exactly one cycle, with `busy` low.
- R9: Toggle requests seen during a clear are ignored, and the cleared pattern still reads all zero afterwards.
- R10: When a clear and a toggle are requested at the same edge in IDLE, the clear is performed and the toggle is dropped.
- R11: A toggle writes to the address and channel that were present when it was accepted. Changes to `pat_sel`, `step` or `chan_sel` during `busy` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 1 | Pattern select, top address bit |
| step | input | 4 | Current step number |
| chan_sel | input | 7 | Channel selector, one line per channel |
| toggle_req | input | 1 | Request to invert the selected channel bit of the current step |
| clear_req | input | 1 | Request to clear the selected pattern |
| rd_word | output | 8 | Word stored at the current address |
| chan_num | output | 3 | Encoded channel number |
| busy | output | 1 | Toggle or clear in progress |
| clear_done | output | 1 | One-cycle flag after a clear finishes |

## Verification
The assertions assume the following about the inputs:
- Requests are sampled only at rising edges.
- During a toggle or a clear, the address and channel inputs may change freely, because the controller latches them.
- The selector may have any number of lines set.

The stimulus drives every input one time unit after a rising edge, so each value is stable across the following edge. The stimulus deliberately includes these cases:
- selectors with several lines set;
- requests held high through a whole toggle;
- toggles issued in the middle of a clear;
- a clear and a toggle requested together;
- address changes during a busy toggle.

These cover the cases where the requirements allow the inputs to misbehave.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_WRITE,
        ST_CLEAR,
        ST_DONE
    } ctl_state_e;
endpackage

// File: rtl/chan_encoder.sv
module chan_encoder #(
    parameter int NCH  = 7,
    parameter int NUMW = $clog2(NCH)
) (
    input  logic [NCH-1:0]  sel,
    output logic [NUMW-1:0] num,
    output logic [NCH-1:0]  mask
);
    // Scanning from the top down lets the lowest set line win.
    always_comb begin
        num  = '0;
        mask = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (sel[i]) begin
                num     = NUMW'(i);
                mask    = '0;
                mask[i] = 1'b1;
            end
        end
    end

    always_comb begin
        assert_mask_onehot_R3: assert ($onehot0(mask));
        if (sel != '0) begin
            assert_mask_matches_num_R3: assert (mask[num] && sel[num]);
        end
    end
endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int WW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] disp_addr,
    output logic [WW-1:0] disp_data,
    input  logic [AW-1:0] rmw_addr,
    output logic [WW-1:0] rmw_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign disp_data = mem[disp_addr];
    assign rmw_data  = mem[rmw_addr];

    // A write lands in the addressed word and is visible on the next cycle.
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rmw_addr == waddr) |=> (rmw_data == $past(wdata) || $past(rmw_addr) != rmw_addr));
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
    import pms_pkg::*;
#(
    parameter int SW  = 4,
    parameter int WW  = 8,
    parameter int NCH = 7,
    parameter int AW  = SW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           toggle_req,
    input  logic           clear_req,
    input  logic           pat_sel,
    input  logic [SW-1:0]  step,
    input  logic [NCH-1:0] mask,
    input  logic [WW-1:0]  rmw_data,
    output logic [AW-1:0]  rmw_addr,
    output logic           we,
    output logic [AW-1:0]  waddr,
    output logic [WW-1:0]  wdata,
    output logic           busy,
    output logic           clear_done
);
    localparam logic [SW-1:0] LAST_STEP = {SW{1'b1}};

    ctl_state_e    st, st_nxt;
    logic [AW-1:0] addr_q;
    logic [NCH-1:0] mask_q;
    logic [WW-1:0] hold_q;
    logic          pat_q;
    logic [SW-1:0] cnt_q;
    logic [WW-1:0] mask_word;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Next-state logic.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (clear_req) begin
                    st_nxt = ST_CLEAR;
                end else if (toggle_req) begin
                    st_nxt = ST_CAPTURE;
                end
            end
            ST_CAPTURE: st_nxt = ST_WRITE;
            ST_WRITE:   st_nxt = ST_IDLE;
            ST_CLEAR: begin
                if (cnt_q == LAST_STEP) begin
                    st_nxt = ST_DONE;
                end
            end
            ST_DONE:    st_nxt = ST_IDLE;
            default:    st_nxt = ST_IDLE;
        endcase
    end

    // Datapath registers: latched address, mask, holding word, sweep counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
            hold_q <= '0;
            pat_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    addr_q <= {pat_sel, step};
                    mask_q <= mask;
                    pat_q  <= pat_sel;
                    cnt_q  <= '0;
                end
                ST_CAPTURE: hold_q <= rmw_data ^ mask_word;
                ST_CLEAR:   cnt_q  <= cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        mask_word = '0;
        mask_word[NCH-1:0] = mask_q;
    end

    // Output logic.
    always_comb begin
        we         = 1'b0;
        waddr      = addr_q;
        wdata      = hold_q;
        busy       = 1'b0;
        clear_done = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_CAPTURE: busy = 1'b1;
            ST_WRITE: begin
                busy = 1'b1;
                we   = 1'b1;
            end
            ST_CLEAR: begin
                busy  = 1'b1;
                we    = 1'b1;
                waddr = {pat_q, cnt_q};
                wdata = '0;
            end
            ST_DONE: clear_done = 1'b1;
            default: ;
        endcase
    end

    assign rmw_addr = addr_q;

    assert_capture_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE) |=> (st == ST_WRITE));
    assert_write_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE) |=> (st == ST_IDLE));
    assert_clear_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR) |=> (st == ST_CLEAR || st == ST_DONE));
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR && cnt_q == LAST_STEP) |=> clear_done);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_done |=> !clear_done);
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && clear_req) |=> (st == ST_CLEAR));
    assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE) |=> $stable(addr_q));
endmodule

// File: rtl/step_pattern_store.sv
module step_pattern_store #(
    parameter int NCH  = 7,
    parameter int WW   = 8,
    parameter int SW   = 4,
    parameter int NUMW = $clog2(NCH),
    parameter int AW   = SW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pat_sel,
    input  logic [SW-1:0]   step,
    input  logic [NCH-1:0]  chan_sel,
    input  logic            toggle_req,
    input  logic            clear_req,
    output logic [WW-1:0]   rd_word,
    output logic [NUMW-1:0] chan_num,
    output logic            busy,
    output logic            clear_done
);
    logic [NCH-1:0] mask;
    logic [AW-1:0]  rmw_addr;
    logic [WW-1:0]  rmw_data;
    logic           we;
    logic [AW-1:0]  waddr;
    logic [WW-1:0]  wdata;

    chan_encoder #(.NCH(NCH), .NUMW(NUMW)) u_enc (
        .sel  (chan_sel),
        .num  (chan_num),
        .mask (mask)
    );

    step_ctrl #(.SW(SW), .WW(WW), .NCH(NCH), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .toggle_req (toggle_req),
        .clear_req  (clear_req),
        .pat_sel    (pat_sel),
        .step       (step),
        .mask       (mask),
        .rmw_data   (rmw_data),
        .rmw_addr   (rmw_addr),
        .we         (we),
        .waddr      (waddr),
        .wdata      (wdata),
        .busy       (busy),
        .clear_done (clear_done)
    );

    word_store #(.WW(WW), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_addr ({pat_sel, step}),
        .disp_data (rd_word),
        .rmw_addr  (rmw_addr),
        .rmw_data  (rmw_data),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata)
    );

    assert_busy_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && clear_done));
    assert_top_bit_never_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word[WW-1] == 1'b0));
endmodule

// File: tb/step_pattern_store_bench.sv
module step_pattern_store_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pat_sel = 1'b0;
    logic [3:0] step = '0;
    logic [6:0] chan_sel = '0;
    logic       toggle_req = 1'b0;
    logic       clear_req = 1'b0;
    logic [7:0] rd_word;
    logic [2:0] chan_num;
    logic       busy;
    logic       clear_done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] model [32];

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sbq [$];

    always #5 clk = ~clk;

    step_pattern_store u_step_pattern_store (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .step(step),
        .chan_sel(chan_sel), .toggle_req(toggle_req), .clear_req(clear_req),
        .rd_word(rd_word), .chan_num(chan_num), .busy(busy), .clear_done(clear_done)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected word and compares it with the read port.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            check(it.tag, rd_word, it.exp);
        end
    end

    function automatic logic [7:0] bench_mask(input logic [6:0] c);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < 7; i++) begin
            if (c[i] && m == 8'h00) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Driver: sets the address and pushes the expected word for the monitor.
    task automatic expect_word(input logic p, input logic [3:0] s, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        pat_sel = p;
        step = s;
        it.exp = model[{p, s}];
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic expect_all(input string tag);
        for (int a = 0; a < 32; a++) expect_word(a[4], a[3:0], tag);
    endtask

    task automatic do_toggle(input logic p, input logic [3:0] s, input logic [6:0] c);
        @(posedge clk); #1;
        pat_sel = p; step = s; chan_sel = c; toggle_req = 1'b1;
        @(posedge clk); #1;
        toggle_req = 1'b0;
        check("R5 busy in capture", {7'b0, busy}, 8'h01);
        @(posedge clk); #1;
        check("R5 busy in write", {7'b0, busy}, 8'h01);
        @(posedge clk); #1;
        check("R5 busy low after write", {7'b0, busy}, 8'h00);
        model[{p, s}] = model[{p, s}] ^ bench_mask(c);
    endtask

    task automatic do_clear(input logic p, input logic with_toggle, input logic mid_toggle);
        @(posedge clk); #1;
        pat_sel = p; clear_req = 1'b1; toggle_req = with_toggle; chan_sel = 7'b0000001;
        @(posedge clk); #1;
        clear_req = 1'b0; toggle_req = 1'b0;
        for (int k = 0; k < 16; k++) begin
            check("R8 busy during sweep", {7'b0, busy}, 8'h01);
            check("R8 done low during sweep", {7'b0, clear_done}, 8'h00);
            pat_sel = ~p;
            step = k[3:0];
            toggle_req = mid_toggle && (k == 5 || k == 6);
            @(posedge clk); #1;
        end
        toggle_req = 1'b0;
        check("R8 done pulse", {7'b0, clear_done}, 8'h01);
        check("R8 busy low at done", {7'b0, busy}, 8'h00);
        @(posedge clk); #1;
        check("R8 done single cycle", {7'b0, clear_done}, 8'h00);
        check("R9 no toggle after clear", {7'b0, busy}, 8'h00);
        for (int k = 0; k < 16; k++) model[{p, k[3:0]}] = 8'h00;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 32; a++) model[a] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 busy after reset", {7'b0, busy}, 8'h00);
        check("R1 done after reset", {7'b0, clear_done}, 8'h00);
        expect_all("R1 reset contents");

        // R3 encoder patterns
        chan_sel = 7'b0000000; #1 check("R3 none", {5'b0, chan_num}, 8'd0);
        chan_sel = 7'b0000001; #1 check("R3 ch0", {5'b0, chan_num}, 8'd0);
        chan_sel = 7'b0000100; #1 check("R3 ch2", {5'b0, chan_num}, 8'd2);
        chan_sel = 7'b1000000; #1 check("R3 ch6", {5'b0, chan_num}, 8'd6);
        chan_sel = 7'b1010100; #1 check("R3 lowest wins", {5'b0, chan_num}, 8'd2);

        // R4 toggles at several addresses and channels
        do_toggle(1'b0, 4'd0, 7'b0000001);
        do_toggle(1'b0, 4'd3, 7'b1000000);
        do_toggle(1'b1, 4'd15, 7'b0010000);
        do_toggle(1'b0, 4'd3, 7'b0000010);
        do_toggle(1'b1, 4'd7, 7'b1100100);
        do_toggle(1'b1, 4'd7, 7'b0000000);
        expect_all("R4 toggle results");
        do_toggle(1'b0, 4'd3, 7'b1000000);
        expect_word(1'b0, 4'd3, "R4 second toggle restores bit");

        // R2 address following within the same cycle
        @(posedge clk); #1;
        pat_sel = 1'b1; step = 4'd15; #1;
        check("R2 immediate read", rd_word, model[5'd31]);
        step = 4'd7; #1;
        check("R2 follows step", rd_word, model[5'd23]);

        // R6 request held for three edges gives one inversion
        @(posedge clk); #1;
        pat_sel = 1'b0; step = 4'd9; chan_sel = 7'b0001000; toggle_req = 1'b1;
        repeat (3) @(posedge clk);
        #1 toggle_req = 1'b0;
        model[5'd9] = model[5'd9] ^ 8'h08;
        @(posedge clk); #1;
        expect_word(1'b0, 4'd9, "R6 single inversion");

        // R11 address and channel changed during busy
        @(posedge clk); #1;
        pat_sel = 1'b0; step = 4'd10; chan_sel = 7'b0100000; toggle_req = 1'b1;
        @(posedge clk); #1;
        toggle_req = 1'b0; step = 4'd11; pat_sel = 1'b1; chan_sel = 7'b0000001;
        repeat (2) @(posedge clk);
        model[5'd10] = model[5'd10] ^ 8'h20;
        expect_word(1'b0, 4'd10, "R11 latched address written");
        expect_word(1'b0, 4'd11, "R11 live address untouched");
        expect_word(1'b1, 4'd11, "R11 other pattern untouched");

        // R7 clear pattern 0, pattern 1 kept
        for (int k = 0; k < 16; k++) do_toggle(1'b0, k[3:0], 7'b0000100);
        do_clear(1'b0, 1'b0, 1'b0);
        expect_all("R7 clear selected pattern only");

        // R9 toggles during a clear are dropped
        do_toggle(1'b1, 4'd2, 7'b0000001);
        do_clear(1'b1, 1'b0, 1'b1);
        expect_all("R9 pattern zero after clear with toggles");

        // R10 simultaneous clear and toggle
        do_toggle(1'b0, 4'd4, 7'b0000010);
        do_toggle(1'b1, 4'd4, 7'b0000010);
        step = 4'd4;
        do_clear(1'b0, 1'b1, 1'b0);
        expect_all("R10 clear wins over toggle");

        repeat (3) @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule